// File: doc/BRIEF.md
# Scaled-Index Effective Address Unit

This block is a single registered stage that forms a memory address from up to three terms: a base value, an index value multiplied by a small power of two, and a signed displacement. Each term has its own enable, so the stage covers all the usual addressing forms. These are displacement alone, base alone, base with displacement, scaled index with displacement, and all three together. The operand values come from whichever general registers the decoder picked, and the displacement comes from the instruction encoding.

The inputs are presented with a valid strobe. One clock later the stage returns the sum, truncated to 32 bits, with its own valid strobe. A reserved scale code on an index that is in use raises an error flag next to the result. The stage never stalls and never holds back a request. It accepts one request every cycle.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is held, and after it is released until the first accepted request, `ea_valid` is 0, `ea_addr` is 0 and `ea_scale_err` is 0.
- R2: `ea_valid` equals `req_valid` from the previous clock cycle, so every request produces exactly one result one cycle later.
- R3: For an accepted request the result is base + index × multiplier + extended displacement, computed over every enabled term.
- R4: Scale code 0 multiplies the index by 1, code 1 by 2 and code 2 by 4. The multiply is a left shift by the code value.
- R5: Scale code 3 with `idx_en`=1 sets `ea_scale_err` to 1 with the result, and the index then contributes zero. In every other case `ea_scale_err` is 0 with the result.
- R6: Displacement size code 0 adds nothing. Code 1 sign-extends bits 7:0 of `disp_val`, code 2 sign-extends bits 15:0, and code 3 uses all 32 bits. Bits above the selected field have no effect.
- R7: `base_en`=0 makes the base contribute zero, whatever `base_val` holds. `idx_en`=0 makes the index contribute zero whatever `idx_val` and `scale_code` hold, and no scale error is raised in that case.
- R8: The sum wraps modulo 2^32, and a carry out of bit 31 is dropped.
- R9: A cycle with `req_valid`=0 leaves `ea_addr` unchanged and clears `ea_scale_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; the operands are taken on this edge |
| base_val | input | 32 | Base register value |
| base_en | input | 1 | Base term is present |
| idx_val | input | 32 | Index register value |
| idx_en | input | 1 | Index term is present |
| scale_code | input | 2 | Index multiplier code (0:×1, 1:×2, 2:×4, 3:reserved) |
| disp_val | input | 32 | Displacement field, right-aligned |
| disp_size | input | 2 | Displacement size (0:none, 1:8-bit, 2:16-bit, 3:32-bit) |
| ea_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| ea_addr | output | 32 | Effective address |
| ea_scale_err | output | 1 | Reserved scale code was used on an enabled index |

## Verification
The hardest case to reach is one where a disabled term carries values that would change the result if they leaked into the sum. Typical examples are an all-ones base, a nonzero index with the reserved scale code, and junk above a short displacement field. Random operands almost never line up this way while the output still shows a leak. The directed tasks therefore load each disabled input with a pattern chosen to move the result far from the expected value. They also place sign bits at 7 and 15 with garbage above them, and they pick base and displacement pairs whose sum carries past bit 31.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [1:0] {
    SC_X1  = 2'd0,
    SC_X2  = 2'd1,
    SC_X4  = 2'd2,
    SC_RSV = 2'd3
  } scale_e;

  typedef enum logic [1:0] {
    DS_NONE = 2'd0,
    DS_B8   = 2'd1,
    DS_B16  = 2'd2,
    DS_FULL = 2'd3
  } dsize_e;

  localparam int unsigned SHORT_W = 8;
  localparam int unsigned MID_W   = 16;

endpackage

// File: rtl/eau_disp_ext.sv
module eau_disp_ext
  import eau_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] raw,
  input  dsize_e       size,
  output logic [W-1:0] term
);

  localparam int unsigned PAD8  = W - SHORT_W;
  localparam int unsigned PAD16 = W - MID_W;

  function automatic logic [W-1:0] widen8(input logic [W-1:0] v);
    return {{PAD8{v[SHORT_W-1]}}, v[SHORT_W-1:0]};
  endfunction

  function automatic logic [W-1:0] widen16(input logic [W-1:0] v);
    return {{PAD16{v[MID_W-1]}}, v[MID_W-1:0]};
  endfunction

  always_comb begin
    unique case (size)
      DS_NONE: term = '0;
      DS_B8:   term = widen8(raw);
      DS_B16:  term = widen16(raw);
      default: term = raw;
    endcase
  end

endmodule

// File: rtl/eau_index_scale.sv
module eau_index_scale
  import eau_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] idx,
  input  logic         en,
  input  scale_e       scale,
  output logic [W-1:0] term,
  output logic         bad
);

  function automatic logic [W-1:0] shifted(input logic [W-1:0] v,
                                           input scale_e s);
    logic [W-1:0] r;
    unique case (s)
      SC_X1:   r = v;
      SC_X2:   r = {v[W-2:0], 1'b0};
      SC_X4:   r = {v[W-3:0], 2'b00};
      default: r = '0;
    endcase
    return r;
  endfunction

  always_comb begin
    bad  = en && (scale == SC_RSV);
    term = en ? shifted(idx, scale) : '0;
  end

endmodule

// File: rtl/eau_sum3.sv
module eau_sum3 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum
);

  function automatic logic [W-1:0] wrap_add3(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic [W-1:0] z);
    logic [W-1:0] s;
    s = x + y;
    s = s + z;
    return s;
  endfunction

  assign sum = wrap_add3(a, b, c);

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit
  import eau_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              base_en,
  input  logic [ADDR_W-1:0] idx_val,
  input  logic              idx_en,
  input  logic [1:0]        scale_code,
  input  logic [ADDR_W-1:0] disp_val,
  input  logic [1:0]        disp_size,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              ea_scale_err
);

  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] disp_term;
  logic [ADDR_W-1:0] sum_next;
  logic              scale_bad;

  assign base_term = base_en ? base_val : '0;

  eau_index_scale #(.W(ADDR_W)) u_scale (
    .idx   (idx_val),
    .en    (idx_en),
    .scale (scale_e'(scale_code)),
    .term  (idx_term),
    .bad   (scale_bad)
  );

  eau_disp_ext #(.W(ADDR_W)) u_disp (
    .raw  (disp_val),
    .size (dsize_e'(disp_size)),
    .term (disp_term)
  );

  eau_sum3 #(.W(ADDR_W)) u_sum (
    .a   (base_term),
    .b   (idx_term),
    .c   (disp_term),
    .sum (sum_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea_valid     <= 1'b0;
      ea_addr      <= '0;
      ea_scale_err <= 1'b0;
    end else begin
      ea_valid     <= req_valid;
      ea_scale_err <= req_valid && scale_bad;
      if (req_valid) ea_addr <= sum_next;
    end
  end

endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         base_en,
  input logic         idx_en,
  input logic [1:0]   scale_code,
  input logic [W-1:0] disp_val,
  input logic [1:0]   disp_size,
  input logic         ea_valid,
  input logic [W-1:0] ea_addr,
  input logic         ea_scale_err,
  input logic [W-1:0] idx_term,
  input logic         scale_bad
);

  a_r2_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ea_valid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !ea_valid);

  a_r5_err_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_en && scale_code == 2'd3) |=> ea_scale_err);

  a_r5_err_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ea_scale_err |-> ea_valid);

  a_r7_no_err_without_index: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !idx_en) |=> !ea_scale_err);

  a_r7_index_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_en |-> (idx_term == '0 && !scale_bad));

  a_r6_full_disp_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !base_en && !idx_en && disp_size == 2'd3)
      |=> ea_addr == $past(disp_val));

  a_r6_nothing_gives_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !base_en && !idx_en && disp_size == 2'd0) |=> ea_addr == '0);

  a_r9_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(ea_addr));

endmodule

bind eff_addr_unit eau_checker #(.W(ADDR_W)) u_eau_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .base_en      (base_en),
  .idx_en       (idx_en),
  .scale_code   (scale_code),
  .disp_val     (disp_val),
  .disp_size    (disp_size),
  .ea_valid     (ea_valid),
  .ea_addr      (ea_addr),
  .ea_scale_err (ea_scale_err),
  .idx_term     (idx_term),
  .scale_bad    (scale_bad)
);

// File: tb/test_eff_addr_unit.sv
module test_eff_addr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] base_val = '0;
  logic        base_en = 1'b0;
  logic [31:0] idx_val = '0;
  logic        idx_en = 1'b0;
  logic [1:0]  scale_code = '0;
  logic [31:0] disp_val = '0;
  logic [1:0]  disp_size = '0;
  logic        ea_valid;
  logic [31:0] ea_addr;
  logic        ea_scale_err;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  eff_addr_unit i_eff_addr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .base_val(base_val), .base_en(base_en),
    .idx_val(idx_val), .idx_en(idx_en), .scale_code(scale_code),
    .disp_val(disp_val), .disp_size(disp_size),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_scale_err(ea_scale_err)
  );

  function automatic logic [31:0] model(input logic [31:0] b, input logic be,
                                        input logic [31:0] x, input logic xe,
                                        input logic [1:0] sc,
                                        input logic [31:0] d, input logic [1:0] ds);
    logic [31:0] dd, xx, bb;
    case (ds)
      2'd0: dd = 32'd0;
      2'd1: dd = $unsigned(32'($signed(d[7:0])));
      2'd2: dd = $unsigned(32'($signed(d[15:0])));
      default: dd = d;
    endcase
    if (xe && sc != 2'd3) xx = x * (32'd1 << sc);
    else xx = 32'd0;
    bb = be ? b : 32'd0;
    return bb + xx + dd;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [31:0] b, input logic be,
                       input logic [31:0] x, input logic xe, input logic [1:0] sc,
                       input logic [31:0] d, input logic [1:0] ds);
    logic [31:0] exp;
    exp = model(b, be, x, xe, sc, d, ds);
    @(negedge clk);
    req_valid = 1'b1; base_val = b; base_en = be; idx_val = x; idx_en = xe;
    scale_code = sc; disp_val = d; disp_size = ds;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, {31'd0, ea_valid}, 32'd1);
    check({req, " addr"}, ea_addr, exp);
    check({req, " err"}, {31'd0, ea_scale_err}, {31'd0, (xe && sc == 2'd3)});
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 valid", {31'd0, ea_valid}, 32'd0);
    check("R1 addr", ea_addr, 32'd0);
    check("R1 err", {31'd0, ea_scale_err}, 32'd0);
  endtask

  task automatic t_single_terms;
    issue("R3 base only", 32'h1234_5678, 1, 32'hFFFF_FFFF, 0, 2'd2, 32'hAAAA_AAAA, 2'd0);
    issue("R6 disp full alone", 32'hDEAD_BEEF, 0, 32'h55, 0, 2'd0, 32'h8000_0010, 2'd3);
    issue("R3 base plus disp", 32'h0000_1000, 1, 32'd0, 0, 2'd0, 32'h0000_0024, 2'd3);
  endtask

  task automatic t_scales;
    issue("R4 x1", 32'h100, 1, 32'h10, 1, 2'd0, 32'd0, 2'd0);
    issue("R4 x2", 32'h100, 1, 32'h10, 1, 2'd1, 32'd0, 2'd0);
    issue("R4 x4", 32'h100, 1, 32'h10, 1, 2'd2, 32'd0, 2'd0);
    issue("R4 x4 top bits drop", 32'd0, 0, 32'hC000_0003, 1, 2'd2, 32'd4, 2'd1);
  endtask

  task automatic t_disp_sizes;
    issue("R6 b8 negative junk", 32'h1000, 1, 32'd0, 0, 2'd0, 32'h1234_56F0, 2'd1);
    issue("R6 b8 positive junk", 32'h1000, 1, 32'd0, 0, 2'd0, 32'hFFFF_FF7F, 2'd1);
    issue("R6 b16 negative", 32'h1_0000, 1, 32'd0, 0, 2'd0, 32'h7777_8000, 2'd2);
    issue("R6 none ignores value", 32'h40, 1, 32'd0, 0, 2'd0, 32'hFFFF_FFFF, 2'd0);
  endtask

  task automatic t_absent_and_reserved;
    issue("R7 both absent", 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0, 2'd3, 32'h7F, 2'd1);
    issue("R5 reserved scale", 32'h2000, 1, 32'h0000_0500, 1, 2'd3, 32'h8, 2'd1);
    issue("R3 full form", 32'h0040_0000, 1, 32'h0000_0003, 1, 2'd2, 32'hFFFC, 2'd2);
  endtask

  task automatic t_wrap;
    issue("R8 wrap", 32'hFFFF_FFF0, 1, 32'h0000_0008, 1, 2'd1, 32'h0000_0020, 2'd3);
  endtask

  task automatic t_idle;
    logic [31:0] last;
    issue("R9 setup with err", 32'h10, 1, 32'h1, 1, 2'd3, 32'd0, 2'd0);
    last = ea_addr;
    @(negedge clk);
    base_val = 32'h9999_9999; base_en = 1'b1; disp_size = 2'd3; disp_val = 32'h1;
    @(negedge clk);
    check("R2 valid low after idle", {31'd0, ea_valid}, 32'd0);
    check("R9 addr held", ea_addr, last);
    check("R9 err cleared", {31'd0, ea_scale_err}, 32'd0);
  endtask

  task automatic t_back_to_back;
    logic [31:0] e1, e2;
    e1 = model(32'h100, 1, 32'h2, 1, 2'd1, 32'd0, 2'd0);
    e2 = model(32'h200, 1, 32'h2, 1, 2'd2, 32'h3, 2'd1);
    @(negedge clk);
    req_valid = 1'b1; base_val = 32'h100; base_en = 1; idx_val = 32'h2; idx_en = 1;
    scale_code = 2'd1; disp_size = 2'd0;
    @(negedge clk);
    check("R2 first of pair", ea_addr, e1);
    base_val = 32'h200; scale_code = 2'd2; disp_val = 32'h3; disp_size = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 second of pair", ea_addr, e2);
    check("R2 pair valid", {31'd0, ea_valid}, 32'd1);
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_single_terms();
    t_scales();
    t_disp_sizes();
    t_absent_and_reserved();
    t_wrap();
    t_idle();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule